// File: doc/BRIEF.md
# Dual-Source I2C Master Clock Generator

This block produces the SCL waveform that an I2C master puts on the bus. A select input picks one of two time bases. In timer mode, each overflow pulse from an external timer flips the SCL level. Each half-period therefore lasts one overflow period, and the bit rate is half the overflow rate. If the timer is an 8-bit auto-reload counter, the bit rate is PCLK / (2 × (256 − reload)). In counter mode, an internal up-counter times the low phase against one count register and the high phase against another. The two phases are set independently, so the duty cycle can be anything.

The block watches the real bus level on an input, which is the wired-AND of its own drive and every other device on the bus. While SCL is released but another device still holds it low, the block waits. It emits one-cycle strobes on each falling and rising edge of the observed bus level. The byte shifter uses the falling strobe to change data and the rising strobe to sample it. In slave mode the block never pulls SCL low and ignores both time bases. Its strobes then follow the clock of the external master, which may run at up to 400 kHz. Dropping the run enable releases SCL and clears all timing state.

Top module: `scl_gen`

## Requirements
- R1: While runEn is low, sclOut is 1 (released) from the next cycle on, and neither strobe is asserted whatever sclIn does.
- R2: In counter mode (masterMode = 1, srcSel = 0), when runEn rises SCL first stays high for highCount cycles and is then driven low, because counting starts from zero.
- R3: In counter mode, each low phase lasts lowCount cycles and each high phase lasts highCount cycles, counted while sclIn is high, so the two phases are independent.
- R4: A count register holding 0 behaves as if it held 1.
- R5: In timer mode (masterMode = 1, srcSel = 1), each one-cycle tmrOvf pulse flips SCL. Nothing else changes it, and the count registers are ignored, so each half-period equals the overflow period.
- R6: While sclOut is released but sclIn is held low by another device, high-phase counting pauses and SCL is not driven low. Counting resumes when sclIn goes high.
- R7: While runEn is high, sclFall pulses for one cycle in the cycle in which sclIn goes from 1 to 0, and sclRise pulses for one cycle in the cycle in which it goes from 0 to 1. This holds in every mode.
- R8: With masterMode = 0, sclOut stays 1 and srcSel, tmrOvf and the count registers have no effect. The strobes follow the edges of the external clock seen on sclIn.
- R9: Dropping runEn in the middle of a phase releases SCL on the next cycle and clears the counter. The next enable restarts timing exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Run enable; low releases SCL and clears timing |
| masterMode | input | 1 | 1 = master (block drives SCL), 0 = slave |
| srcSel | input | 1 | 1 = timer-overflow time base, 0 = internal counter |
| tmrOvf | input | 1 | One-cycle timer overflow strobe |
| lowCount | input | CNT_W | Low-phase length in cycles (0 acts as 1) |
| highCount | input | CNT_W | High-phase length in cycles (0 acts as 1) |
| sclIn | input | 1 | Observed bus SCL level (wired-AND of all drivers) |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sclRise | output | 1 | One-cycle strobe on a rising bus edge |
| sclFall | output | 1 | One-cycle strobe on a falling bus edge |

## Verification
The assertions assume that the count registers, srcSel and masterMode stay constant while the block runs. They also assume that sclIn is the wired-AND of sclOut with any external pull-down, so it can never be high while the block drives low. The bench changes mode and counts only while runEn is low. It models the bus exactly as that wired-AND, and it changes the external pull-down and the overflow strobe only between clock edges.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Strobes from the control section to the datapath, one cycle each.
  typedef struct packed {
    logic clrCnt;   // zero the phase counter
    logic incCnt;   // advance the phase counter
    logic drvLow;   // pull SCL low
    logic drvRel;   // release SCL
  } sclStrb_t;

endpackage

// File: rtl/scl_gen_dpath.sv
module scl_gen_dpath
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             sclIn,
  input  sclStrb_t         strb,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  output logic             sclLvl,
  output logic             lowHit,
  output logic             highHit,
  output logic             sclRise,
  output logic             sclFall
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lowEff;
  logic [CNT_W-1:0] highEff;
  logic             sclPrev;

  // A programmed zero is stretched to one cycle.
  assign lowEff  = (lowCount  == '0) ? ONE : lowCount;
  assign highEff = (highCount == '0) ? ONE : highCount;

  // Terminal compare; >= keeps a phase finite if a count is lowered.
  assign lowHit  = (cnt >= (lowEff  - ONE));
  assign highHit = (cnt >= (highEff - ONE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (strb.incCnt) cnt <= cnt + ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sclLvl <= 1'b1;
    else if (strb.drvRel) sclLvl <= 1'b1;
    else if (strb.drvLow) sclLvl <= 1'b0;
  end

  // Edge detection on the observed bus level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclIn;
  end

  assign sclRise = runEn &  sclIn & ~sclPrev;
  assign sclFall = runEn & ~sclIn &  sclPrev;

  // R3
  low_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sclLvl |-> (cnt < lowEff));

  // R7
  fall_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $fell(sclIn)) |-> sclFall);

  // R7
  rise_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $rose(sclIn)) |-> sclRise);

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  input  logic     masterMode,
  input  logic     srcSel,
  input  logic     tmrOvf,
  input  logic     sclIn,
  input  logic     sclLvl,
  input  logic     lowHit,
  input  logic     highHit,
  output sclStrb_t strb
);

  logic active;

  assign active = runEn & masterMode;

  always_comb begin
    strb = '0;
    if (!active) begin
      strb.clrCnt = 1'b1;
      strb.drvRel = 1'b1;
    end else if (srcSel) begin
      // Timer base: counter idle, each overflow flips the level.
      strb.clrCnt = 1'b1;
      if (tmrOvf) begin
        if (!sclLvl)    strb.drvRel = 1'b1;
        else if (sclIn) strb.drvLow = 1'b1;
      end
    end else if (!sclLvl) begin
      if (lowHit) begin
        strb.drvRel = 1'b1;
        strb.clrCnt = 1'b1;
      end else begin
        strb.incCnt = 1'b1;
      end
    end else if (sclIn) begin
      if (highHit) begin
        strb.drvLow = 1'b1;
        strb.clrCnt = 1'b1;
      end else begin
        strb.incCnt = 1'b1;
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> sclLvl);

  // R8
  slave_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> sclLvl);

  // R5
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && srcSel && !tmrOvf) |=> $stable(sclLvl));

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && sclLvl && !sclIn) |=> sclLvl);

endmodule

// File: rtl/scl_gen.sv
module scl_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             masterMode,
  input  logic             srcSel,
  input  logic             tmrOvf,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             sclIn,
  output logic             sclOut,
  output logic             sclRise,
  output logic             sclFall
);

  sclStrb_t strb;
  logic     sclLvl;
  logic     lowHit;
  logic     highHit;

  scl_gen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .masterMode (masterMode),
    .srcSel     (srcSel),
    .tmrOvf     (tmrOvf),
    .sclIn      (sclIn),
    .sclLvl     (sclLvl),
    .lowHit     (lowHit),
    .highHit    (highHit),
    .strb       (strb)
  );

  scl_gen_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .sclIn     (sclIn),
    .strb      (strb),
    .lowCount  (lowCount),
    .highCount (highCount),
    .sclLvl    (sclLvl),
    .lowHit    (lowHit),
    .highHit   (highHit),
    .sclRise   (sclRise),
    .sclFall   (sclFall)
  );

  assign sclOut = sclLvl;

endmodule

// File: tb/test_scl_gen.sv
module test_scl_gen;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             runEn = 1'b0;
  logic             masterMode = 1'b1;
  logic             srcSel = 1'b0;
  logic             tmrOvf = 1'b0;
  logic [CNT_W-1:0] lowCount = 8'd4;
  logic [CNT_W-1:0] highCount = 8'd4;
  logic             extLow = 1'b0;
  logic             sclIn;
  logic             sclOut;
  logic             sclRise;
  logic             sclFall;

  int total = 0;
  int bad = 0;
  int cycCnt = 0;
  int markCyc = 0;
  bit finished = 0;

  // expected-event scoreboard
  bit expRise[$];
  int expGap[$];
  int expReq[$];

  bit ovfOn = 0;
  int ovfPer = 6;
  int ovfCnt = 0;

  assign sclIn = sclOut & ~extLow;   // wired-AND bus

  always #2 clk = ~clk;              // 250 MHz

  scl_gen #(.CNT_W(CNT_W)) i_scl_gen (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .masterMode (masterMode),
    .srcSel     (srcSel),
    .tmrOvf     (tmrOvf),
    .lowCount   (lowCount),
    .highCount  (highCount),
    .sclIn      (sclIn),
    .sclOut     (sclOut),
    .sclRise    (sclRise),
    .sclFall    (sclFall)
  );

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // timer overflow model
  always @(negedge clk) begin
    if (!ovfOn) begin
      ovfCnt = 0;
      tmrOvf = 1'b0;
    end else if (ovfCnt == ovfPer - 1) begin
      ovfCnt = 0;
      tmrOvf = 1'b1;
    end else begin
      ovfCnt = ovfCnt + 1;
      tmrOvf = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pops and compares each strobe
  always @(negedge clk) begin
    if (rstN && (sclRise || sclFall)) begin
      if (expRise.size() == 0) begin
        check(1'b0, "R1 unexpected strobe", int'(sclRise), 0);
      end else begin
        automatic bit r = expRise.pop_front();
        automatic int g = expGap.pop_front();
        automatic int q = expReq.pop_front();
        automatic string tag = $sformatf("R%0d", q);
        check(sclRise == r && !(sclRise && sclFall), {tag, " edge kind"},
              int'(sclRise), int'(r));
        if (g >= 0)
          check((cycCnt - markCyc) == g, {tag, " gap"}, cycCnt - markCyc, g);
      end
      markCyc = cycCnt;
    end
  end

  task automatic push(input bit r, input int g, input int q);
    expRise.push_back(r);
    expGap.push_back(g);
    expReq.push_back(q);
  endtask

  task automatic startRun();
    @(negedge clk);
    markCyc = cycCnt;
    runEn = 1'b1;
  endtask

  task automatic finishRun(input string req);
    bit done = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      if (expRise.size() == 0) begin
        done = 1;
        break;
      end
    end
    check(done, {req, " all edges seen"}, expRise.size(), 0);
    runEn = 1'b0;
    ovfOn = 0;
    expRise.delete();
    expGap.delete();
    expReq.delete();
    @(posedge clk);
    #1;
    check(sclOut == 1'b1, "R1 released after disable", int'(sclOut), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state and strobes gated while disabled
    check(sclOut == 1'b1, "R1 reset level", int'(sclOut), 1);
    @(posedge clk); #1 extLow = 1'b1;
    @(posedge clk); #1 extLow = 1'b0;
    repeat (2) @(negedge clk);
    check(sclOut == 1'b1, "R1 idle level", int'(sclOut), 1);

    // R2/R3: counter mode, low 5, high 3
    lowCount = 8'd5; highCount = 8'd3;
    push(0, 3, 2); push(1, 5, 3); push(0, 3, 3); push(1, 5, 3); push(0, 3, 3);
    startRun();
    finishRun("R3");

    // R3: strongly asymmetric duty, low 2, high 7
    lowCount = 8'd2; highCount = 8'd7;
    push(0, 7, 2); push(1, 2, 3); push(0, 7, 3); push(1, 2, 3);
    startRun();
    finishRun("R3");

    // R4: zero counts act as one
    lowCount = 8'd0; highCount = 8'd0;
    push(0, 1, 4); push(1, 1, 4); push(0, 1, 4); push(1, 1, 4);
    startRun();
    finishRun("R4");

    // R5: timer base, counts ignored, half-period = overflow period
    srcSel = 1'b1; lowCount = 8'd2; highCount = 8'd2; ovfPer = 6;
    push(0, -1, 5); push(1, 6, 5); push(0, 6, 5); push(1, 6, 5);
    ovfOn = 1;
    startRun();
    finishRun("R5");
    srcSel = 1'b0;

    // R6: release held low by another device
    lowCount = 8'd3; highCount = 8'd4;
    extLow = 1'b1;
    push(1, -1, 6); push(0, 4, 6); push(1, 3, 6); push(0, 4, 6);
    startRun();
    repeat (10) @(negedge clk);
    check(expRise.size() == 4, "R6 no edge while held", expRise.size(), 4);
    check(sclOut == 1'b1, "R6 released while held", int'(sclOut), 1);
    @(posedge clk); #1 extLow = 1'b0;
    finishRun("R6");

    // R8: slave mode follows external clock, ignores time bases
    masterMode = 1'b0; srcSel = 1'b1; ovfPer = 3; ovfOn = 1;
    push(0, -1, 8); push(1, 4, 8); push(0, 4, 8); push(1, 4, 8);
    startRun();
    begin
      bit drove = 0;
      repeat (2) @(posedge clk);
      #1 extLow = 1'b1;
      for (int k = 0; k < 12; k++) begin
        @(posedge clk);
        #1;
        if (sclOut != 1'b1) drove = 1;
        if (k == 3 || k == 11) extLow = 1'b0;
        if (k == 7) extLow = 1'b1;
      end
      check(!drove, "R8 never driven low", int'(drove), 0);
    end
    finishRun("R8");
    masterMode = 1'b1; srcSel = 1'b0;

    // R9: disable in the middle of the low phase, then restart
    lowCount = 8'd6; highCount = 8'd2;
    push(0, 2, 2);
    startRun();
    for (int i = 0; i < 50 && expRise.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    #1 runEn = 1'b0;
    @(posedge clk); #1;
    check(sclOut == 1'b1, "R9 release on disable", int'(sclOut), 1);
    repeat (3) @(negedge clk);
    push(0, 2, 9); push(1, 6, 9);
    startRun();
    finishRun("R9");

    finish();
  end

endmodule